// File: doc/BRIEF.md
# Effective Address Generator for Register/Memory Operand Bytes

The block takes the decoded fields of an operand-specifier byte (mode, register/memory selector), the optional scaled-index byte (scale, index, base) and a raw displacement, and forms a 32-bit effective address. Two combinational register-file read ports supply the base and index register values in the same cycle the request is accepted. The result is registered in one pipeline stage with a valid/ready handshake on both sides.

Besides ordinary memory operands, the block serves an address-only operation. In that operation the computed sum goes to a destination register and no memory access is requested. When the mode field selects a register operand, no address is formed and the selected register index is reported instead.

Top module: `eag_top`

## Requirements
- R1: With mode `11` the output reports a register operand: `outIsReg`=1, `outRegIdx` = the selector field, `outAddr`=0, `outMemOp`=0, `outWrEn`=0.
- R2: With mode `00`, `01` or `10` and a selector that is neither `100` nor (mode `00` with selector `101`), the address is the register named by the selector plus the displacement.
- R3: Mode `01` adds the low 8 displacement bits sign-extended to 32 bits; mode `10` adds all 32 displacement bits; mode `00` adds no displacement except in the R6 cases.
- R4: Selector `100` with mode other than `11` uses the scaled-index fields: address = base register + (index register shifted left by the scale code, so codes 00/01/10/11 give factors 1/2/4/8) + displacement.
- R5: A scaled-index index code of `100` means no index term.
- R6: Mode `00` with selector `101` gives the 32-bit displacement alone; in scaled-index form, mode `00` with base code `101` drops the base term and adds the 32-bit displacement.
- R7: The address sum wraps modulo 2^32.
- R8: With `addrOnly`=1 and a memory-form operand, the result has `outWrEn`=1, `outWrIdx`=`dstReg`, `outMemOp`=0; without `addrOnly` a memory-form operand has `outMemOp`=1 and `outWrEn`=0. No flag-update output exists, so flags are never touched.
- R9: `inReady` is high when the output stage is empty or being drained; an accepted request appears on the outputs on the next clock edge, and while `outValid`=1 and `outReady`=0 the outputs hold and no new request is taken.
- R10: After reset `outValid`=0 and `inReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request can be taken |
| modField | input | 2 | Addressing mode field |
| rmField | input | 3 | Register/memory selector field |
| sibScale | input | 2 | Scale code |
| sibIndex | input | 3 | Index register code |
| sibBase | input | 3 | Base register code |
| dispIn | input | 32 | Raw displacement |
| addrOnly | input | 1 | Address-only operation |
| dstReg | input | 3 | Destination register for address-only |
| rdIdxA | output | 3 | Read port A index (base) |
| rdDataA | input | 32 | Read port A data |
| rdIdxB | output | 3 | Read port B index (index) |
| rdDataB | input | 32 | Read port B data |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Result consumed |
| outAddr | output | 32 | Effective address / address-only result |
| outIsReg | output | 1 | Operand is a register |
| outRegIdx | output | 3 | Register operand index |
| outMemOp | output | 1 | Memory access required |
| outWrEn | output | 1 | Register write of outAddr required |
| outWrIdx | output | 3 | Register to write |

## Verification
Every result is due exactly one clock edge after the request is accepted, so the bench drives a request before a falling edge, lets one rising edge pass, and compares all outputs at the following falling edge. The register file is modelled in the bench and its read data follows the read indices combinationally, so the operands seen at acceptance are the ones the bench's model uses. The stall case holds `outReady` low for several cycles and checks at each falling edge that the held result is unchanged and `inReady` is low, then checks that the waiting request lands one edge after release.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int ADDR_W  = 32;
  localparam int REG_W   = 3;
  localparam int SCALE_W = 2;
  localparam int BYTE_W  = 8;

  localparam logic [1:0]       MOD_REG   = 2'b11;
  localparam logic [1:0]       MOD_NODSP = 2'b00;
  localparam logic [1:0]       MOD_D8    = 2'b01;
  localparam logic [REG_W-1:0] RM_SIB    = 3'b100;
  localparam logic [REG_W-1:0] RM_ABS    = 3'b101;
  localparam logic [REG_W-1:0] IDX_NONE  = 3'b100;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } dispSel_e;

  typedef struct packed {
    logic     load;
    logic     isReg;
    logic     sibMode;
    logic     useBase;
    logic     useIndex;
    dispSel_e dispSel;
    logic     memOp;
    logic     wrEn;
  } eagCtrl_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic             outReady,
  output logic             outValid,
  input  logic [1:0]       modField,
  input  logic [REG_W-1:0] rmField,
  input  logic [REG_W-1:0] sibIndex,
  input  logic [REG_W-1:0] sibBase,
  input  logic             addrOnly,
  output eagCtrl_t         ctrl
);
  logic validQ;

  assign inReady  = !validQ || outReady;
  assign outValid = validQ;

  always_comb begin
    ctrl          = '0;
    ctrl.load     = inValid && inReady;
    ctrl.isReg    = (modField == MOD_REG);
    ctrl.sibMode  = !ctrl.isReg && (rmField == RM_SIB);
    if (ctrl.isReg) begin
      ctrl.dispSel = DISP_NONE;
    end else if (modField == MOD_D8) begin
      ctrl.dispSel = DISP_BYTE;
    end else if (modField == MOD_NODSP) begin
      if (ctrl.sibMode) ctrl.dispSel = (sibBase == RM_ABS) ? DISP_WORD : DISP_NONE;
      else              ctrl.dispSel = (rmField == RM_ABS) ? DISP_WORD : DISP_NONE;
    end else begin
      ctrl.dispSel = DISP_WORD;
    end
    if (ctrl.sibMode) begin
      ctrl.useBase  = !((modField == MOD_NODSP) && (sibBase == RM_ABS));
      ctrl.useIndex = (sibIndex != IDX_NONE);
    end else begin
      ctrl.useBase  = !ctrl.isReg && !((modField == MOD_NODSP) && (rmField == RM_ABS));
      ctrl.useIndex = 1'b0;
    end
    ctrl.memOp = !ctrl.isReg && !addrOnly;
    ctrl.wrEn  = !ctrl.isReg && addrOnly;
  end

  always_ff @(posedge clk) begin
    if (rst)          validQ <= 1'b0;
    else if (inReady) validQ <= inValid;
  end
endmodule

// File: rtl/eag_dp.sv
module eag_dp
  import eag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  eagCtrl_t           ctrl,
  input  logic [REG_W-1:0]   rmField,
  input  logic [SCALE_W-1:0] sibScale,
  input  logic [REG_W-1:0]   sibIndex,
  input  logic [REG_W-1:0]   sibBase,
  input  logic [ADDR_W-1:0]  dispIn,
  input  logic [REG_W-1:0]   dstReg,
  output logic [REG_W-1:0]   rdIdxA,
  input  logic [ADDR_W-1:0]  rdDataA,
  output logic [REG_W-1:0]   rdIdxB,
  input  logic [ADDR_W-1:0]  rdDataB,
  output logic [ADDR_W-1:0]  outAddr,
  output logic               outIsReg,
  output logic [REG_W-1:0]   outRegIdx,
  output logic               outMemOp,
  output logic               outWrEn,
  output logic [REG_W-1:0]   outWrIdx
);
  localparam int EXT_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] baseTerm, indexTerm, dispTerm, sum;

  assign rdIdxA = ctrl.sibMode ? sibBase : rmField;
  assign rdIdxB = sibIndex;

  always_comb begin
    baseTerm  = ctrl.useBase  ? rdDataA : '0;
    indexTerm = ctrl.useIndex ? (rdDataB << sibScale) : '0;
    unique case (ctrl.dispSel)
      DISP_BYTE: dispTerm = {{EXT_W{dispIn[BYTE_W-1]}}, dispIn[BYTE_W-1:0]};
      DISP_WORD: dispTerm = dispIn;
      default:   dispTerm = '0;
    endcase
    sum = baseTerm + indexTerm + dispTerm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outAddr   <= '0;
      outIsReg  <= 1'b0;
      outRegIdx <= '0;
      outMemOp  <= 1'b0;
      outWrEn   <= 1'b0;
      outWrIdx  <= '0;
    end else if (ctrl.load) begin
      outAddr   <= ctrl.isReg ? '0 : sum;
      outIsReg  <= ctrl.isReg;
      outRegIdx <= ctrl.isReg ? rmField : '0;
      outMemOp  <= ctrl.memOp;
      outWrEn   <= ctrl.wrEn;
      outWrIdx  <= ctrl.wrEn ? dstReg : '0;
    end
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [1:0]         modField,
  input  logic [REG_W-1:0]   rmField,
  input  logic [SCALE_W-1:0] sibScale,
  input  logic [REG_W-1:0]   sibIndex,
  input  logic [REG_W-1:0]   sibBase,
  input  logic [ADDR_W-1:0]  dispIn,
  input  logic               addrOnly,
  input  logic [REG_W-1:0]   dstReg,
  output logic [REG_W-1:0]   rdIdxA,
  input  logic [ADDR_W-1:0]  rdDataA,
  output logic [REG_W-1:0]   rdIdxB,
  input  logic [ADDR_W-1:0]  rdDataB,
  output logic               outValid,
  input  logic               outReady,
  output logic [ADDR_W-1:0]  outAddr,
  output logic               outIsReg,
  output logic [REG_W-1:0]   outRegIdx,
  output logic               outMemOp,
  output logic               outWrEn,
  output logic [REG_W-1:0]   outWrIdx
);
  eagCtrl_t ctrl;

  eag_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .modField(modField),
    .rmField(rmField), .sibIndex(sibIndex), .sibBase(sibBase),
    .addrOnly(addrOnly), .ctrl(ctrl)
  );

  eag_dp u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .rmField(rmField),
    .sibScale(sibScale), .sibIndex(sibIndex), .sibBase(sibBase),
    .dispIn(dispIn), .dstReg(dstReg), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdDataB(rdDataB), .outAddr(outAddr),
    .outIsReg(outIsReg), .outRegIdx(outRegIdx), .outMemOp(outMemOp),
    .outWrEn(outWrEn), .outWrIdx(outWrIdx)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk
  import eag_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outIsReg,
  input logic              outMemOp,
  input logic              outWrEn
);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outIsReg));

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> outValid);

  p_regop_r1: assert property (@(posedge clk) disable iff (rst)
    outValid && outIsReg |-> !outMemOp && !outWrEn && (outAddr == '0));

  p_onekind_r8: assert property (@(posedge clk) disable iff (rst)
    outValid && !outIsReg |-> (outMemOp != outWrEn));

  p_stallblock_r9: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady);
endmodule

bind eag_top eag_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
  .outIsReg(outIsReg), .outMemOp(outMemOp), .outWrEn(outWrEn)
);

// File: tb/sim_eag_top.sv
`timescale 1ns/1ps
module sim_eag_top;
  logic clk = 0, rst = 1;
  logic inValid = 0, inReady, addrOnly = 0, outValid, outReady = 1;
  logic [1:0] modField = 0, sibScale = 0;
  logic [2:0] rmField = 0, sibIndex = 0, sibBase = 0, dstReg = 0;
  logic [2:0] rdIdxA, rdIdxB, outRegIdx, outWrIdx;
  logic [31:0] dispIn = 0, rdDataA, rdDataB, outAddr;
  logic outIsReg, outMemOp, outWrEn;
  logic [31:0] rf [8];
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rdDataA = rf[rdIdxA];
  assign rdDataB = rf[rdIdxB];

  eag_top u0 (.*);

  function automatic logic [31:0] expAddr(logic [1:0] m, logic [2:0] r, logic [1:0] s,
                                          logic [2:0] ix, logic [2:0] b, logic [31:0] d);
    logic [31:0] a, dd;
    if (m == 2'b11) return 32'h0;
    dd = (m == 2'b01) ? {{24{d[7]}}, d[7:0]} : (m == 2'b10) ? d : 32'h0;
    if (r == 3'b100) begin
      a = 0;
      if (m == 2'b00 && b == 3'b101) dd = d; else a = rf[b];
      if (ix != 3'b100) a = a + rf[ix] * (32'd1 << s);
    end else if (m == 2'b00 && r == 3'b101) begin
      a = 0; dd = d;
    end else a = rf[r];
    return a + dd;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] m, logic [2:0] r, logic [1:0] s, logic [2:0] ix,
                       logic [2:0] b, logic [31:0] d, logic ao, logic [2:0] dst);
    string tag;
    logic [31:0] ea;
    logic isR;
    @(negedge clk);
    modField = m; rmField = r; sibScale = s; sibIndex = ix; sibBase = b;
    dispIn = d; addrOnly = ao; dstReg = dst; inValid = 1;
    ea = expAddr(m, r, s, ix, b, d);
    isR = (m == 2'b11);
    @(negedge clk);
    inValid = 0;
    if (isR) tag = "R1";
    else if (ao) tag = "R8";
    else if (r == 3'b100) tag = (ix == 3'b100) ? "R5" : "R4";
    else if (m == 2'b00 && r == 3'b101) tag = "R6";
    else tag = "R2/R3/R7";
    chk({tag, " valid"}, {63'd0, outValid}, 64'd1);
    chk({tag, " addr"}, {32'd0, outAddr}, {32'd0, ea});
    chk({tag, " isReg"}, {63'd0, outIsReg}, {63'd0, isR});
    chk({tag, " regIdx"}, {61'd0, outRegIdx}, {61'd0, isR ? r : 3'd0});
    chk({tag, " memOp"}, {63'd0, outMemOp}, {63'd0, !isR && !ao});
    chk({tag, " wrEn"}, {63'd0, outWrEn}, {63'd0, !isR && ao});
    chk({tag, " wrIdx"}, {61'd0, outWrIdx}, {61'd0, (!isR && ao) ? dst : 3'd0});
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog act=running exp=finished");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 * (i + 1) + i;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 outValid", {63'd0, outValid}, 64'd0);
    chk("R10 inReady", {63'd0, inReady}, 64'd1);
    // directed corners
    apply(2'b11, 3'd6, 0, 0, 0, 32'hdead, 0, 0);             // R1
    apply(2'b01, 3'd2, 0, 0, 0, 32'h0000_0080, 0, 0);        // R3 negative byte
    apply(2'b01, 3'd2, 0, 0, 0, 32'hffff_ff7f, 0, 0);        // R3 positive byte
    apply(2'b10, 3'd3, 0, 0, 0, 32'h8000_0001, 0, 0);        // R3 word
    apply(2'b00, 3'd5, 0, 0, 0, 32'h1234_5678, 0, 0);        // R6 absolute
    apply(2'b00, 3'd4, 2'd3, 3'd1, 3'd5, 32'h0000_0100, 0, 0); // R6 no base
    apply(2'b01, 3'd4, 2'd2, 3'd4, 3'd7, 32'h0000_00f0, 0, 0); // R5 no index
    for (int s = 0; s < 4; s++) apply(2'b10, 3'd4, s[1:0], 3'd2, 3'd0, 32'h10, 0, 0); // R4
    rf[6] = 32'hffff_fff0;
    apply(2'b10, 3'd6, 0, 0, 0, 32'h0000_0020, 0, 0);        // R7 wrap
    apply(2'b01, 3'd4, 2'd1, 3'd3, 3'd0, 32'h4, 1, 3'd5);    // R8 address-only
    apply(2'b11, 3'd1, 0, 0, 0, 0, 1, 3'd2);                 // R1 with addrOnly
    // R9 stall
    @(negedge clk);
    outReady = 0;
    modField = 2'b10; rmField = 3'd0; dispIn = 32'h111; addrOnly = 0; inValid = 1;
    @(negedge clk);
    dispIn = 32'h222;
    chk("R9 first", {32'd0, outAddr}, {32'd0, rf[0] + 32'h111});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 hold", {32'd0, outAddr}, {32'd0, rf[0] + 32'h111});
      chk("R9 inReady low", {63'd0, inReady}, 64'd0);
    end
    outReady = 1;
    @(negedge clk);
    inValid = 0;
    chk("R9 second", {32'd0, outAddr}, {32'd0, rf[0] + 32'h222});
    @(negedge clk);
    chk("R9 drained", {63'd0, outValid}, 64'd0);
    // random
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 8; i++) rf[i] = $urandom;
      apply($urandom % 4, $urandom % 8, $urandom % 4, $urandom % 8, $urandom % 8,
            $urandom, $urandom % 2, $urandom % 8);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule